// File: doc/BRIEF.md
# Scheduled Bufferless Circuit Switch

This block is a small crossbar with no storage for cells. In every time slot each input port is tied to exactly one output port, and the pairing is fixed by a rotating schedule. The block never looks at the cell contents, never arbitrates and never buffers. A shared time base pulses `slot_start` once per slot. On that pulse the switch moves to the next schedule entry. For a guard interval after the pulse it sends nothing, and during that interval the crossbar reconfigures.

With `NUM_PORTS` = N, slot s (which runs from 1 to N-1) sends input p to output (p+s) mod N. Over N-1 slots every ordered pair of distinct ports is therefore connected exactly once. Several copies of the block that are fed the same strobe step through their schedules in lockstep. The output path has one register stage. Reconfiguration needs no more than the strobe cycle plus `GUARD_CYCLES` clock cycles.

Top module: `sched_circuit_switch`

## Requirements
- R1: When `rst` is sampled high, the next outputs have every `out_valid` bit at 0 and `out_data` at zero, and the slot index returns to 1.
- R2: From reset until the first sampled `slot_start`, the outputs stay idle whatever the inputs carry.
- R3: In a forwarding cycle, output o at the next edge shows the `in_valid` bit and the cell (`CELL_W` bits at o*`CELL_W`) of input (o-s) mod N, where s is the current slot index. Outside forwarding, `out_data` is zero.
- R4: Each slot's mapping is a permutation with no port mapped to itself. Over one period of N-1 slots, every ordered pair of distinct ports is connected.
- R5: The first `slot_start` after reset begins slot 1. Each later strobe advances the slot by one, and slot N-1 wraps to 1.
- R6: A `slot_start` sampled at edge k makes the outputs idle for edges k through k+`GUARD_CYCLES`. Forwarding with the new mapping resumes at edge k+`GUARD_CYCLES`+1.
- R7: Routing depends only on the schedule: the valid flag and the cell bits travel unchanged, and no cell content changes which output they reach.
- R8: A `slot_start` that arrives inside a guard interval advances the slot again and restarts the full guard interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_start | input | 1 | One-cycle strobe from the shared time base that opens a slot |
| in_data | input | NUM_PORTS*CELL_W | Input cells, port p at bits p*CELL_W |
| in_valid | input | NUM_PORTS | Per-input cell valid |
| out_data | output | NUM_PORTS*CELL_W | Permuted cells, registered |
| out_valid | output | NUM_PORTS | Permuted valid flags, registered |

## Verification
The assertions assume `rst` is high at the first clock edge, so that the slot index and guard counter start defined. They also assume `slot_start` is an ordinary single-bit level that the time base drives cleanly. The stimulus holds reset for several cycles at the start and asserts it again once mid-run. It varies the slot length so that some slots have only one forwarding cycle. It fires two strobes back to back to exercise the guard restart. Input cells carry their source port number in their low bits, so the bench can recover which input reached which output.

// File: rtl/csw_pkg.sv
package csw_pkg;

    // Source input feeding output o while slot s is active on an n-port switch
    function automatic int src_port(int o, int s, int n);
        return (o >= s) ? (o - s) : (o + n - s);
    endfunction

endpackage

// File: rtl/csw_slot_seq.sv
module csw_slot_seq #(
    parameter int NUM_PORTS    = 8,
    parameter int GUARD_CYCLES = 2,
    localparam int SLOT_W      = $clog2(NUM_PORTS),
    localparam int GCNT_W      = $clog2(GUARD_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_start,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              started,
    output logic              fwd_en
);

    typedef struct packed {
        logic              started;
        logic [SLOT_W-1:0] slot;
        logic [GCNT_W-1:0] guard;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (slot_start) begin
            seq_d.started = 1'b1;
            seq_d.guard   = GCNT_W'(GUARD_CYCLES);
            if (!seq_q.started || seq_q.slot == SLOT_W'(NUM_PORTS - 1))
                seq_d.slot = SLOT_W'(1);
            else
                seq_d.slot = seq_q.slot + SLOT_W'(1);
        end else if (seq_q.guard != '0) begin
            seq_d.guard = seq_q.guard - GCNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.started <= 1'b0;
            seq_q.slot    <= SLOT_W'(1);
            seq_q.guard   <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign slot_idx = seq_q.slot;
    assign started  = seq_q.started;
    assign fwd_en   = seq_q.started && (seq_q.guard == '0) && !slot_start;

endmodule

// File: rtl/csw_route_map.sv
module csw_route_map #(
    parameter int NUM_PORTS = 8,
    localparam int IDX_W    = $clog2(NUM_PORTS)
) (
    input  logic [IDX_W-1:0]           slot_idx,
    output logic [NUM_PORTS*IDX_W-1:0] src_flat
);

    for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
        assign src_flat[o*IDX_W +: IDX_W] =
            IDX_W'(csw_pkg::src_port(o, int'(slot_idx), NUM_PORTS));
    end

endmodule

// File: rtl/csw_xbar_stage.sv
module csw_xbar_stage #(
    parameter int NUM_PORTS = 8,
    parameter int CELL_W    = 16,
    localparam int IDX_W    = $clog2(NUM_PORTS),
    localparam int BUS_W    = NUM_PORTS * CELL_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fwd_en,
    input  logic [BUS_W-1:0]           in_data,
    input  logic [NUM_PORTS-1:0]       in_valid,
    input  logic [NUM_PORTS*IDX_W-1:0] src_flat,
    output logic [BUS_W-1:0]           out_data,
    output logic [NUM_PORTS-1:0]       out_valid
);

    typedef struct packed {
        logic [BUS_W-1:0]     data;
        logic [NUM_PORTS-1:0] valid;
    } xout_t;

    xout_t xout_d, xout_q;

    always_comb begin
        xout_d = '0;
        for (int o = 0; o < NUM_PORTS; o++) begin
            int sp;
            sp = int'(src_flat[o*IDX_W +: IDX_W]);
            if (fwd_en) begin
                xout_d.valid[o]                = in_valid[sp];
                xout_d.data[o*CELL_W +: CELL_W] = in_data[sp*CELL_W +: CELL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) xout_q <= '0;
        else     xout_q <= xout_d;
    end

    assign out_data  = xout_q.data;
    assign out_valid = xout_q.valid;

endmodule

// File: rtl/sched_circuit_switch.sv
module sched_circuit_switch #(
    parameter int NUM_PORTS    = 8,
    parameter int CELL_W       = 16,
    parameter int GUARD_CYCLES = 2,
    localparam int IDX_W       = $clog2(NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        slot_start,
    input  logic [NUM_PORTS*CELL_W-1:0] in_data,
    input  logic [NUM_PORTS-1:0]        in_valid,
    output logic [NUM_PORTS*CELL_W-1:0] out_data,
    output logic [NUM_PORTS-1:0]        out_valid
);

    logic [IDX_W-1:0]           slot_idx;
    logic                       started;
    logic                       fwd_en;
    logic [NUM_PORTS*IDX_W-1:0] src_flat;

    csw_slot_seq #(
        .NUM_PORTS   (NUM_PORTS),
        .GUARD_CYCLES(GUARD_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .slot_start(slot_start),
        .slot_idx  (slot_idx),
        .started   (started),
        .fwd_en    (fwd_en)
    );

    csw_route_map #(
        .NUM_PORTS(NUM_PORTS)
    ) u_map (
        .slot_idx(slot_idx),
        .src_flat(src_flat)
    );

    csw_xbar_stage #(
        .NUM_PORTS(NUM_PORTS),
        .CELL_W   (CELL_W)
    ) u_xbar (
        .clk      (clk),
        .rst      (rst),
        .fwd_en   (fwd_en),
        .in_data  (in_data),
        .in_valid (in_valid),
        .src_flat (src_flat),
        .out_data (out_data),
        .out_valid(out_valid)
    );

endmodule

// File: rtl/csw_sched_checker.sv
module csw_sched_checker #(
    parameter int NUM_PORTS = 8,
    parameter int CELL_W    = 16,
    localparam int IDX_W    = $clog2(NUM_PORTS)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        slot_start,
    input logic [NUM_PORTS*CELL_W-1:0] out_data,
    input logic [NUM_PORTS-1:0]        out_valid,
    input logic [IDX_W-1:0]            slot_idx,
    input logic                        started,
    input logic [NUM_PORTS*IDX_W-1:0]  src_flat
);

    logic [NUM_PORTS-1:0] used_mask;
    logic [NUM_PORTS-1:0] self_mask;

    always_comb begin
        used_mask = '0;
        self_mask = '0;
        for (int o = 0; o < NUM_PORTS; o++) begin
            used_mask[int'(src_flat[o*IDX_W +: IDX_W])] = 1'b1;
            if (int'(src_flat[o*IDX_W +: IDX_W]) == o) self_mask[o] = 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (out_valid == '0 && out_data == '0 && slot_idx == IDX_W'(1) && !started));

    assert_pre_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !started |-> (out_valid == '0));

    assert_perm_full_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(used_mask) == NUM_PORTS);

    assert_no_self_R4: assert property (@(posedge clk) disable iff (rst)
        self_mask == '0);

    assert_slot_range_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_idx >= IDX_W'(1)) && (slot_idx <= IDX_W'(NUM_PORTS - 1)));

    assert_first_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_start && !started) |=> (started && slot_idx == IDX_W'(1)));

    assert_slot_step_R5: assert property (@(posedge clk) disable iff (rst)
        (slot_start && started) |=>
            (slot_idx == (($past(slot_idx) == IDX_W'(NUM_PORTS - 1)) ? IDX_W'(1)
                                                                      : $past(slot_idx) + IDX_W'(1))));

    assert_guard_blank_R6: assert property (@(posedge clk) disable iff (rst)
        slot_start |=> (out_valid == '0 && out_data == '0));

endmodule

bind sched_circuit_switch csw_sched_checker #(
    .NUM_PORTS(NUM_PORTS),
    .CELL_W   (CELL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .slot_start(slot_start),
    .out_data  (out_data),
    .out_valid (out_valid),
    .slot_idx  (slot_idx),
    .started   (started),
    .src_flat  (src_flat)
);

// File: tb/sched_circuit_switch_tb.sv
module sched_circuit_switch_tb;

    localparam int N     = 8;
    localparam int W     = 16;
    localparam int G     = 2;
    localparam int IDX_W = $clog2(N);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ss  = 1'b0;
    logic [N*W-1:0]   idata = '0;
    logic [N-1:0]     ivld  = '0;
    logic [N*W-1:0]   odata;
    logic [N-1:0]     ovld;

    always #2 clk = ~clk;

    sched_circuit_switch #(.NUM_PORTS(N), .CELL_W(W), .GUARD_CYCLES(G)) u_dut (
        .clk(clk), .rst(rst), .slot_start(ss),
        .in_data(idata), .in_valid(ivld),
        .out_data(odata), .out_valid(ovld)
    );

    // behavioural reference state
    int             m_started = 0;
    int             m_slot    = 1;
    int             m_guard   = 0;
    logic [N*W-1:0] exp_data  = '0;
    logic [N-1:0]   exp_vld   = '0;
    string          exp_tag   = "R1";
    bit             chk_on    = 0;
    bit             seen [N][N];

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    task automatic compare();
        tests++;
        if (odata !== exp_data || ovld !== exp_vld) begin
            fails++;
            $display("FAIL %s: data=%h valid=%b expected data=%h valid=%b",
                     exp_tag, odata, ovld, exp_data, exp_vld);
        end
        // R4 coverage: which input (low bits of cell) reached which output
        for (int o = 0; o < N; o++)
            if (ovld[o]) seen[int'(odata[o*W +: IDX_W])][o] = 1'b1;
    endtask

    task automatic cycle(input logic r, input logic s);
        @(negedge clk);
        if (chk_on) compare();
        rst = r;
        ss  = s;
        ivld = ($urandom % 4 == 0) ? N'($urandom) : '1;
        for (int p = 0; p < N; p++)
            idata[p*W +: W] = {W-IDX_W'($urandom), IDX_W'(p)};
        // model the edge that samples these inputs
        if (r) begin
            exp_tag   = "R1";
            m_started = 0; m_slot = 1; m_guard = 0;
            exp_data  = '0; exp_vld = '0;
        end else begin
            bit fwd;
            fwd = (m_started != 0) && (m_guard == 0) && !s;
            if (m_started == 0)            exp_tag = "R2";
            else if (s && m_guard > 0)     exp_tag = "R8";
            else if (!fwd)                 exp_tag = "R6";
            else                           exp_tag = "R3 R5 R7";
            exp_data = '0; exp_vld = '0;
            if (fwd) begin
                for (int o = 0; o < N; o++) begin
                    int sp;
                    sp = (o - m_slot + N) % N;
                    exp_vld[o]          = ivld[sp];
                    exp_data[o*W +: W]  = idata[sp*W +: W];
                end
            end
            if (s) begin
                m_slot    = (m_started == 0 || m_slot == N - 1) ? 1 : m_slot + 1;
                m_started = 1;
                m_guard   = G;
            end else if (m_guard > 0) begin
                m_guard--;
            end
        end
        chk_on = 1;
    endtask

    task automatic run_slots(input int count, input int base_len);
        for (int k = 0; k < count; k++) begin
            cycle(1'b0, 1'b1);
            for (int c = 0; c < base_len + (k % 3) - 1; c++) cycle(1'b0, 1'b0);
        end
    endtask

    initial begin
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++) seen[a][b] = 1'b0;
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0);      // R1
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0);      // R2 idle before first strobe
        run_slots(18, 4);                                    // R3 R5 R6 R7, shortest slot 1 fwd cycle
        cycle(1'b0, 1'b1); cycle(1'b0, 1'b1);               // R8 strobe inside guard
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b0);
        cycle(1'b1, 1'b0); cycle(1'b1, 1'b0);               // R1 mid-run reset
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0);      // R2 again
        run_slots(9, 6);                                     // R5 wrap past slot N-1
        cycle(1'b0, 1'b0);
        // R4 coverage of all ordered distinct pairs, none to itself
        begin
            int missing, selfhits;
            missing = 0; selfhits = 0;
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++) begin
                    if (a != b && !seen[a][b]) missing++;
                    if (a == b && seen[a][b])  selfhits++;
                end
            tests++;
            if (missing != 0) begin
                fails++;
                $display("FAIL R4: missing pairs=%0d expected 0", missing);
            end
            tests++;
            if (selfhits != 0) begin
                fails++;
                $display("FAIL R4: self connections=%0d expected 0", selfhits);
            end
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule